// File: doc/BRIEF.md
# Link training sequencer

This block runs the two-phase training of a serial display link with one to four lanes. In the first phase it sends pattern 1 and raises the drive level until every active lane reports clock lock. In the second phase it sends pattern 2 or 3 and adjusts drive until the lanes are equalized and aligned to each other. It sets the pattern select and a training byte (swing and pre-emphasis) for the transmitter. It sends pattern writes, training-byte writes and status-block reads to the sink through a simple request/response port. A separate framer, outside this block, carries those requests over the auxiliary channel.

Software or a link manager picks the lane count, says whether the sink accepts pattern 3, and supplies the sink's read-interval value. It then pulses `start`. When the sequence ends, `done` pulses for one cycle. At that point `cr_ok` and `eq_ok` hold the result of each phase, and `train_set` holds the last training byte that was applied.

Top module: `lt_seq`

## Requirements
- R1: After `start`, the requests are issued in this order: a pattern write with value 0, a pattern write with value 1, and a training-byte write with value 0x00. `tp_sel` reads 1 during the clock-lock phase. While `req_ready` is low, a request and its payload are held unchanged.
- R2: Waits are measured in cycles as microseconds times `CLKS_PER_US`.
  - After the first training-byte write there is a settle wait of 400 us.
  - Before each status read there is a poll wait: 100 us in the clock-lock phase and 400 us in the equalization phase when `rd_itv` is 0, otherwise 4000 us times `rd_itv`.
- R3: In the status block, lane n's nibble sits at byte n/2 (byte 0 in bits 7:0), at bit offset 4*(n mod 2). Nibble bit 0 is clock lock. The clock-lock phase passes when bit 0 is set for every lane below `lanes`. Lanes at or above `lanes` have no effect.
- R4: If the status read fails the lock test while the applied training byte already has its max-swing flag set, the clock-lock phase fails.
- R5: A training-byte swing equal to the swing of the previous read counts as a repeat. Any change of swing clears the repeat count. The clock-lock phase fails at the fifth repeat, that is on the sixth read of an unchanging swing.
- R6: Each adjust request is 2 bits of swing at bit offset 4*(n mod 2) and 2 bits of pre-emphasis just above it, in byte 4 + n/2. The new training byte is built as follows:
  - swing is the largest requested swing over the active lanes, in bits 1:0;
  - bit 2 is set when that swing is 3;
  - pre-emphasis is the largest requested pre-emphasis over the active lanes, in bits 4:3;
  - bit 5 is set when that pre-emphasis is 3.
  The byte is written to the sink and driven on `train_set`.
- R7: The equalization phase writes and selects pattern 3 when `tps3_cap` is 1 and pattern 2 otherwise. It runs whatever the outcome of the first phase.
- R8: Equalization passes when bit 0 of status byte 2 (interlane alignment) is set and nibble bits 2:0 are all set for every active lane.
- R9: Equalization fails on the read after six adjustments have been made.
- R10: A read answered with `rsp_err` ends the current phase with failure.
- R11: After both phases, and after a 400 us wait, a pattern write of 0 is issued. Then `tp_sel` returns to 0 and `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a training sequence (accepted when idle) |
| lanes | input | LCNT_W (3) | Active lane count, 1 to MAX_LANES |
| tps3_cap | input | 1 | Sink accepts pattern 3 |
| rd_itv | input | ITV_W (8) | Sink read-interval value |
| req_valid | output | 1 | Request to the register transport |
| req_ready | input | 1 | Transport accepts the request |
| req_op | output | 2 | 0 pattern write, 1 training-byte write, 2 status read |
| req_wdata | output | 8 | Write payload (0 for reads) |
| rsp_valid | input | 1 | Response for the outstanding request |
| rsp_err | input | 1 | Response reports a transport failure |
| rsp_stat | input | 48 | Status block returned by a read |
| tp_sel | output | 2 | Pattern driven by the transmitter (0 none) |
| train_set | output | 8 | Training byte applied to all lanes |
| cr_ok | output | 1 | Clock-lock phase passed |
| eq_ok | output | 1 | Equalization phase passed |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The assertions assume the transport returns exactly one `rsp_valid` for each accepted request, and only after that request has been accepted. They also assume `lanes` lies between 1 and `MAX_LANES` when `start` is pulsed. The bench's responder raises `rsp_valid` only on the cycle after an accepted request, and for reads it returns the next scripted status block. Every scenario keeps `lanes` at 1, 2 or 4 and pulses `start` only while the block is idle.

// File: rtl/lt_pkg.sv
package lt_pkg;
   localparam int STAT_BYTES = 6;
   localparam int STAT_W     = STAT_BYTES * 8;
   localparam int ALIGN_BYTE = 2;
   localparam int ALIGN_BIT  = 0;
   localparam int ADJ_BYTE0  = 4;
   localparam int NIB_LOCK   = 0;
   localparam int NIB_EQ_W   = 3;

   localparam int SETTLE_US  = 400;
   localparam int CR_POLL_US = 100;
   localparam int EQ_POLL_US = 400;
   localparam int STEP_US    = 4000;

   typedef enum logic [1:0] {
      OP_PAT_WR  = 2'd0,
      OP_SET_WR  = 2'd1,
      OP_STAT_RD = 2'd2
   } lt_op_e;

   typedef enum logic [1:0] {
      TP_OFF = 2'd0,
      TP_1   = 2'd1,
      TP_2   = 2'd2,
      TP_3   = 2'd3
   } lt_pat_e;

   typedef enum logic [1:0] {
      W_SETTLE = 2'd0,
      W_CR     = 2'd1,
      W_EQ     = 2'd2
   } lt_wait_e;

   // training byte: [1:0] swing, [2] swing at top, [4:3] pre-emphasis, [5] pre-emphasis at top
   function automatic logic [7:0] pack_train(input logic [1:0] sw, input logic [1:0] pe);
      return {2'b00, (pe == 2'd3), pe, (sw == 2'd3), sw};
   endfunction
endpackage

// File: rtl/lt_wait_timer.sv
module lt_wait_timer
   import lt_pkg::*;
#(
   parameter int CLKS_PER_US = 250,
   parameter int ITV_W       = 8,
   localparam longint MAXV   = longint'(STEP_US) * ((longint'(1) << ITV_W) - 1) * CLKS_PER_US,
   localparam int CNT_W      = $clog2(MAXV + 1)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  lt_wait_e         kind,
   input  logic [ITV_W-1:0] itv,
   output logic             expired
);
   logic [CNT_W-1:0] lval;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic [CNT_W-1:0] step_len;

   assign step_len = CNT_W'(itv) * CNT_W'(STEP_US * CLKS_PER_US);

   always_comb begin
      unique case (kind)
         W_CR:    lval = (itv == '0) ? CNT_W'(CR_POLL_US * CLKS_PER_US) : step_len;
         W_EQ:    lval = (itv == '0) ? CNT_W'(EQ_POLL_US * CLKS_PER_US) : step_len;
         default: lval = CNT_W'(SETTLE_US * CLKS_PER_US);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (load) begin
         run_q <= 1'b1;
         cnt_q <= lval - CNT_W'(1);
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired = run_q & (cnt_q == '0);

   // R2: a running wait counts down by one each cycle
   p_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)))
      else $error("wait counter skipped");
endmodule

// File: rtl/lt_lane_eval.sv
module lt_lane_eval
   import lt_pkg::*;
#(
   parameter int MAX_LANES = 4,
   localparam int LCNT_W   = $clog2(MAX_LANES + 1)
)(
   input  logic [STAT_W-1:0] stat,
   input  logic [LCNT_W-1:0] lanes,
   output logic              lock_all,
   output logic              eq_all,
   output logic [1:0]        sw_max,
   output logic [1:0]        pe_max
);
   logic [MAX_LANES-1:0] act;
   logic [MAX_LANES-1:0] lock;
   logic [MAX_LANES-1:0] eqd;
   logic [1:0]           sw [MAX_LANES];
   logic [1:0]           pe [MAX_LANES];
   logic                 stat_unused;

   for (genvar n = 0; n < MAX_LANES; n++) begin : g_lane
      localparam int NIB_LSB = (n / 2) * 8 + (n % 2) * 4;
      localparam int ADJ_LSB = (ADJ_BYTE0 + n / 2) * 8 + (n % 2) * 4;
      assign act[n]  = (LCNT_W'(n) < lanes);
      assign lock[n] = stat[NIB_LSB + NIB_LOCK];
      assign eqd[n]  = &stat[NIB_LSB +: NIB_EQ_W];
      assign sw[n]   = stat[ADJ_LSB +: 2];
      assign pe[n]   = stat[ADJ_LSB + 2 +: 2];
   end

   assign stat_unused = ^stat;
   assign lock_all    = &(lock | ~act);
   assign eq_all      = stat[ALIGN_BYTE * 8 + ALIGN_BIT] & (&(eqd | ~act));

   always_comb begin
      sw_max = 2'd0;
      pe_max = 2'd0;
      for (int n = 0; n < MAX_LANES; n++) begin
         if (act[n] && sw[n] > sw_max) sw_max = sw[n];
         if (act[n] && pe[n] > pe_max) pe_max = pe[n];
      end
   end
endmodule

// File: rtl/lt_seq.sv
module lt_seq
   import lt_pkg::*;
#(
   parameter int MAX_LANES       = 4,
   parameter int CLKS_PER_US     = 250,
   parameter int ITV_W           = 8,
   parameter int CR_REPEAT_LIMIT = 5,
   parameter int EQ_TRY_LIMIT    = 5,
   localparam int LCNT_W         = $clog2(MAX_LANES + 1),
   localparam int CRT_W          = $clog2(CR_REPEAT_LIMIT + 1),
   localparam int EQT_W          = $clog2(EQ_TRY_LIMIT + 2)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LCNT_W-1:0] lanes,
   input  logic              tps3_cap,
   input  logic [ITV_W-1:0]  rd_itv,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [1:0]        req_op,
   output logic [7:0]        req_wdata,
   input  logic              rsp_valid,
   input  logic              rsp_err,
   input  logic [STAT_W-1:0] rsp_stat,
   output logic [1:0]        tp_sel,
   output logic [7:0]        train_set,
   output logic              cr_ok,
   output logic              eq_ok,
   output logic              done
);
   if (MAX_LANES < 1 || MAX_LANES > 4) begin : g_bad_lanes
      $error("MAX_LANES must lie in 1..4");
   end
   if (ITV_W < 1 || ITV_W > 8) begin : g_bad_itv
      $error("ITV_W must lie in 1..8");
   end
   if (CLKS_PER_US < 1 || CR_REPEAT_LIMIT < 1 || EQ_TRY_LIMIT < 0) begin : g_bad_limits
      $error("timing and retry parameters out of range");
   end

   typedef enum logic [3:0] {
      S_IDLE, S_OFF, S_CR_PAT, S_CR_SET, S_CR_SETTLE, S_CR_WAIT, S_CR_RD, S_CR_ADJ,
      S_EQ_PAT, S_EQ_WAIT, S_EQ_RD, S_EQ_ADJ, S_FIN_WAIT, S_FIN_OFF, S_DONE
   } st_e;

   st_e               state_q;
   logic              issued_q;
   logic [LCNT_W-1:0] lanes_q;
   logic              tps3_q;
   logic [ITV_W-1:0]  itv_q;
   logic [7:0]        train_q;
   lt_pat_e           tp_q;
   logic [1:0]        prev_sw_q;
   logic              prev_v_q;
   logic [CRT_W-1:0]  cr_tries_q;
   logic [EQT_W-1:0]  eq_tries_q;
   logic              cr_ok_q, eq_ok_q;
   logic              t_load_q;
   lt_wait_e          t_kind_q;
   logic              t_exp;

   logic              xact;
   lt_op_e            op_c;
   logic [7:0]        wd_c;
   logic              fire, xend;
   logic              lock_all, eq_all;
   logic [1:0]        sw_max, pe_max;
   logic [7:0]        adj_byte;
   logic              same_sw;

   lt_wait_timer #(.CLKS_PER_US(CLKS_PER_US), .ITV_W(ITV_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load_q), .kind(t_kind_q), .itv(itv_q), .expired(t_exp)
   );

   lt_lane_eval #(.MAX_LANES(MAX_LANES)) u_eval (
      .stat(rsp_stat), .lanes(lanes_q), .lock_all(lock_all), .eq_all(eq_all),
      .sw_max(sw_max), .pe_max(pe_max)
   );

   assign adj_byte = pack_train(sw_max, pe_max);
   assign same_sw  = prev_v_q && (train_q[1:0] == prev_sw_q);

   always_comb begin
      xact = 1'b0;
      op_c = OP_PAT_WR;
      wd_c = 8'h00;
      unique case (state_q)
         S_OFF, S_FIN_OFF:             begin xact = 1'b1; op_c = OP_PAT_WR;  wd_c = {6'b0, TP_OFF}; end
         S_CR_PAT:                     begin xact = 1'b1; op_c = OP_PAT_WR;  wd_c = {6'b0, TP_1};   end
         S_EQ_PAT:                     begin xact = 1'b1; op_c = OP_PAT_WR;  wd_c = {6'b0, tp_q};   end
         S_CR_SET, S_CR_ADJ, S_EQ_ADJ: begin xact = 1'b1; op_c = OP_SET_WR;  wd_c = train_q;        end
         S_CR_RD, S_EQ_RD:             begin xact = 1'b1; op_c = OP_STAT_RD;                         end
         default: ;
      endcase
   end

   assign req_valid = xact & ~issued_q;
   assign req_op    = op_c;
   assign req_wdata = wd_c;
   assign fire      = req_valid & req_ready;
   assign xend      = xact & issued_q & rsp_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         issued_q   <= 1'b0;
         lanes_q    <= '0;
         tps3_q     <= 1'b0;
         itv_q      <= '0;
         train_q    <= 8'h00;
         tp_q       <= TP_OFF;
         prev_sw_q  <= 2'd0;
         prev_v_q   <= 1'b0;
         cr_tries_q <= '0;
         eq_tries_q <= '0;
         cr_ok_q    <= 1'b0;
         eq_ok_q    <= 1'b0;
         t_load_q   <= 1'b0;
         t_kind_q   <= W_SETTLE;
      end else begin
         t_load_q <= 1'b0;
         if (fire)      issued_q <= 1'b1;
         else if (xend) issued_q <= 1'b0;

         unique case (state_q)
            S_IDLE: if (start) begin
               lanes_q <= lanes;
               tps3_q  <= tps3_cap;
               itv_q   <= rd_itv;
               cr_ok_q <= 1'b0;
               eq_ok_q <= 1'b0;
               state_q <= S_OFF;
            end
            S_OFF: if (xend) begin
               tp_q    <= TP_1;
               train_q <= 8'h00;
               state_q <= S_CR_PAT;
            end
            S_CR_PAT: if (xend) state_q <= S_CR_SET;
            S_CR_SET: if (xend) begin
               cr_tries_q <= '0;
               prev_v_q   <= 1'b0;
               t_load_q   <= 1'b1;
               t_kind_q   <= W_SETTLE;
               state_q    <= S_CR_SETTLE;
            end
            S_CR_SETTLE: if (t_exp) begin
               t_load_q <= 1'b1;
               t_kind_q <= W_CR;
               state_q  <= S_CR_WAIT;
            end
            S_CR_WAIT: if (t_exp) state_q <= S_CR_RD;
            S_CR_RD: if (xend) begin
               if (rsp_err || lock_all || train_q[2] ||
                   (same_sw && cr_tries_q + CRT_W'(1) >= CRT_W'(CR_REPEAT_LIMIT))) begin
                  cr_ok_q    <= ~rsp_err & lock_all;
                  tp_q       <= tps3_q ? TP_3 : TP_2;
                  eq_tries_q <= '0;
                  state_q    <= S_EQ_PAT;
               end else begin
                  cr_tries_q <= same_sw ? cr_tries_q + CRT_W'(1) : '0;
                  prev_sw_q  <= train_q[1:0];
                  prev_v_q   <= 1'b1;
                  train_q    <= adj_byte;
                  state_q    <= S_CR_ADJ;
               end
            end
            S_CR_ADJ: if (xend) begin
               t_load_q <= 1'b1;
               t_kind_q <= W_CR;
               state_q  <= S_CR_WAIT;
            end
            S_EQ_PAT: if (xend) begin
               t_load_q <= 1'b1;
               t_kind_q <= W_EQ;
               state_q  <= S_EQ_WAIT;
            end
            S_EQ_WAIT: if (t_exp) state_q <= S_EQ_RD;
            S_EQ_RD: if (xend) begin
               if (rsp_err || eq_all || eq_tries_q > EQT_W'(EQ_TRY_LIMIT)) begin
                  eq_ok_q  <= ~rsp_err & eq_all;
                  t_load_q <= 1'b1;
                  t_kind_q <= W_SETTLE;
                  state_q  <= S_FIN_WAIT;
               end else begin
                  train_q    <= adj_byte;
                  eq_tries_q <= eq_tries_q + EQT_W'(1);
                  state_q    <= S_EQ_ADJ;
               end
            end
            S_EQ_ADJ: if (xend) begin
               t_load_q <= 1'b1;
               t_kind_q <= W_EQ;
               state_q  <= S_EQ_WAIT;
            end
            S_FIN_WAIT: if (t_exp) state_q <= S_FIN_OFF;
            S_FIN_OFF: if (xend) begin
               tp_q    <= TP_OFF;
               state_q <= S_DONE;
            end
            S_DONE:  state_q <= S_IDLE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign tp_sel    = tp_q;
   assign train_set = train_q;
   assign cr_ok     = cr_ok_q;
   assign eq_ok     = eq_ok_q;
   assign done      = (state_q == S_DONE);

   // R1: an unaccepted request keeps its opcode and payload
   p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_op) && $stable(req_wdata)))
      else $error("request changed before acceptance");

   // R11: end-of-sequence marker lasts one cycle
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done held longer than one cycle");

   // R11: transmitter pattern is off whenever the sequencer rests
   p_idle_tp_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE) |-> (tp_sel == 2'd0))
      else $error("pattern left on while idle");

   // R5: the repeat counter stops before reaching its limit
   p_cr_tries_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cr_tries_q < CRT_W'(CR_REPEAT_LIMIT))
      else $error("clock-lock repeat count overran");

   // R9: equalization never exceeds one adjustment past its limit
   p_eq_tries_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eq_tries_q <= EQT_W'(EQ_TRY_LIMIT + 1))
      else $error("equalization attempts overran");
endmodule

// File: tb/lt_seq_tb.sv
module lt_seq_tb;
   import lt_pkg::*;
   localparam int MAXL = 4;
   localparam int LW   = $clog2(MAXL + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [LW-1:0]     lanes = LW'(1);
   logic              tps3 = 1'b0;
   logic [7:0]        itv = 8'd0;
   logic              req_ready = 1'b1;
   logic              rsp_valid = 1'b0;
   logic              rsp_err = 1'b0;
   logic [STAT_W-1:0] rsp_stat = '0;
   logic              req_valid;
   logic [1:0]        req_op;
   logic [7:0]        req_wdata;
   logic [1:0]        tp_sel;
   logic [7:0]        train_set;
   logic              cr_ok, eq_ok, done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   int    exp_op[$];
   int    exp_wd[$];
   int    exp_tp[$];
   string exp_tag[$];
   logic [STAT_W:0] stq[$];
   int    acc_c[$];

   lt_seq #(.MAX_LANES(MAXL), .CLKS_PER_US(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .lanes(lanes), .tps3_cap(tps3), .rd_itv(itv),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_stat(rsp_stat),
      .tp_sel(tp_sel), .train_set(train_set), .cr_ok(cr_ok), .eq_ok(eq_ok), .done(done)
   );

   always #2 clk = ~clk;

   initial forever begin
      @(posedge clk);
      cyc++;
   end

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   function automatic void summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endfunction

   task automatic ex(input int op, input int wd, input int tp, input string tag);
      exp_op.push_back(op);
      exp_wd.push_back(wd);
      exp_tp.push_back(tp);
      exp_tag.push_back(tag);
   endtask

   task automatic st(input logic err, input logic [7:0] b0, input logic [7:0] b1,
                     input logic [7:0] b2, input logic [7:0] b4, input logic [7:0] b5);
      stq.push_back({err, b5, b4, 8'h00, b2, b1, b0});
   endtask

   // monitor and responder: compares each accepted request with the scoreboard
   initial begin
      bit pend = 1'b0;
      int pop;
      forever begin
         @(negedge clk);
         if (rsp_valid) rsp_valid = 1'b0;
         if (pend) begin
            rsp_valid = 1'b1;
            rsp_err   = 1'b0;
            rsp_stat  = '0;
            if (pop == 2) begin
               logic [STAT_W:0] e;
               e = (stq.size() > 0) ? stq.pop_front() : '0;
               rsp_err  = e[STAT_W];
               rsp_stat = e[STAT_W-1:0];
            end
            pend = 1'b0;
         end
         if (req_valid) begin
            acc_c.push_back(cyc);
            pop = int'(req_op);
            if (exp_op.size() == 0) begin
               chk(1'b0, "R1", "unexpected request op", int'(req_op), -1);
            end else begin
               int o, w, t;
               string g;
               o = exp_op.pop_front();
               w = exp_wd.pop_front();
               t = exp_tp.pop_front();
               g = exp_tag.pop_front();
               chk(int'(req_op) == o, g, "request op", int'(req_op), o);
               if (o != 2) chk(int'(req_wdata) == w, g, "write data", int'(req_wdata), w);
               if (t >= 0) chk(int'(tp_sel) == t, g, "tp_sel at read", int'(tp_sel), t);
            end
            pend = 1'b1;
         end
      end
   end

   task automatic gap(input int i, input int j, input int lo, input int hi, input string tag);
      int d;
      d = (acc_c.size() > j) ? acc_c[j] - acc_c[i] : -1;
      chk(d >= lo && d <= hi, tag, "request spacing", d, lo);
   endtask

   task automatic run(input int nl, input bit t3, input int iv, input bit ecr, input string crtag,
                      input bit eeq, input string eqtag, input logic [7:0] etr, input string trtag);
      int lim = 0;
      acc_c.delete();
      @(negedge clk);
      lanes = LW'(nl);
      tps3  = t3;
      itv   = 8'(iv);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && lim < 60000) begin
         @(negedge clk);
         lim++;
      end
      chk(done == 1'b1, "R11", "done reached", int'(done), 1);
      chk(cr_ok == ecr, crtag, "cr_ok", int'(cr_ok), int'(ecr));
      chk(eq_ok == eeq, eqtag, "eq_ok", int'(eq_ok), int'(eeq));
      chk(train_set == etr, trtag, "train_set", int'(train_set), int'(etr));
      chk(tp_sel == 2'd0, "R11", "tp_sel after done", int'(tp_sel), 0);
      chk(exp_op.size() == 0, "R11", "requests left unissued", exp_op.size(), 0);
      @(negedge clk);
      chk(done == 1'b0, "R11", "done width", int'(done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual %0d expected done", cyc);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_valid == 1'b0, "R1", "req_valid in reset", int'(req_valid), 0);
      chk(tp_sel == 2'd0 && done == 1'b0, "R11", "tp_sel/done in reset", int'({tp_sel, done}), 0);
      chk(train_set == 8'h00 && !cr_ok && !eq_ok, "R6", "outputs in reset", int'(train_set), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // S1: four lanes, immediate success in both phases, pattern 3
      ex(0, 0, -1, "R1"); ex(0, 1, -1, "R1"); ex(1, 8'h00, -1, "R1");
      ex(2, 0, 1, "R1");  ex(0, 3, -1, "R7"); ex(2, 0, 3, "R7"); ex(0, 0, -1, "R11");
      st(1'b0, 8'h11, 8'h11, 8'h00, 8'h00, 8'h00);
      st(1'b0, 8'h77, 8'h77, 8'h01, 8'h00, 8'h00);
      run(4, 1'b1, 0, 1'b1, "R3", 1'b1, "R8", 8'h00, "R6");
      gap(2, 3, 500, 508, "R2");
      gap(4, 5, 400, 408, "R2");
      gap(5, 6, 400, 408, "R11");

      // S2: two lanes, adjust merges active lanes only, pattern 2
      ex(0, 0, -1, "R1"); ex(0, 1, -1, "R1"); ex(1, 8'h00, -1, "R1");
      ex(2, 0, 1, "R3");  ex(1, 8'h0A, -1, "R6"); ex(2, 0, 1, "R3");
      ex(0, 2, -1, "R7"); ex(2, 0, 2, "R8"); ex(1, 8'h3F, -1, "R6"); ex(2, 0, 2, "R8");
      ex(0, 0, -1, "R11");
      st(1'b0, 8'h01, 8'h00, 8'h00, 8'h61, 8'hFF);
      st(1'b0, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00);
      st(1'b0, 8'h77, 8'h00, 8'h00, 8'h0F, 8'h00);
      st(1'b0, 8'h77, 8'h00, 8'h01, 8'h00, 8'h00);
      run(2, 1'b0, 0, 1'b1, "R3", 1'b1, "R8", 8'h3F, "R6");

      // S3: one lane, unchanging swing fails on fifth repeat; equalization limit
      ex(0, 0, -1, "R1"); ex(0, 1, -1, "R1"); ex(1, 8'h00, -1, "R1");
      ex(2, 0, 1, "R5");
      for (int k = 0; k < 5; k++) begin
         ex(1, 8'h00, -1, "R5"); ex(2, 0, 1, "R5");
      end
      ex(0, 2, -1, "R7");
      for (int k = 0; k < 6; k++) begin
         ex(2, 0, 2, "R9"); ex(1, 8'h00, -1, "R9");
      end
      ex(2, 0, 2, "R9"); ex(0, 0, -1, "R11");
      for (int k = 0; k < 6; k++) st(1'b0, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
      for (int k = 0; k < 7; k++) st(1'b0, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00);
      run(1, 1'b0, 0, 1'b0, "R5", 1'b0, "R9", 8'h00, "R6");

      // S4: four lanes, lane 3 asks for top swing, then abort at max swing
      ex(0, 0, -1, "R1"); ex(0, 1, -1, "R1"); ex(1, 8'h00, -1, "R1");
      ex(2, 0, 1, "R4"); ex(1, 8'h07, -1, "R6"); ex(2, 0, 1, "R4");
      ex(0, 3, -1, "R7"); ex(2, 0, 3, "R8"); ex(0, 0, -1, "R11");
      st(1'b0, 8'h11, 8'h01, 8'h00, 8'h00, 8'h30);
      st(1'b0, 8'h11, 8'h01, 8'h00, 8'h00, 8'h30);
      st(1'b0, 8'h77, 8'h77, 8'h01, 8'h00, 8'h00);
      run(4, 1'b1, 0, 1'b0, "R4", 1'b1, "R8", 8'h07, "R6");

      // S5: read errors end each phase; interval value 1 lengthens polling
      ex(0, 0, -1, "R1"); ex(0, 1, -1, "R1"); ex(1, 8'h00, -1, "R1");
      ex(2, 0, 1, "R10"); ex(0, 3, -1, "R7"); ex(2, 0, 3, "R10"); ex(0, 0, -1, "R11");
      st(1'b1, 8'h11, 8'h11, 8'h01, 8'h00, 8'h00);
      st(1'b1, 8'h77, 8'h77, 8'h01, 8'h00, 8'h00);
      run(2, 1'b1, 1, 1'b0, "R10", 1'b0, "R10", 8'h00, "R6");
      gap(2, 3, 4400, 4408, "R2");
      gap(4, 5, 4000, 4008, "R2");

      summary();
      $finish;
   end
endmodule